// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block sits beside shared memory and keeps, for every memory block, a record of which processor caches hold a copy. Each record is a presence vector with one bit per processor, plus a sole-writer flag that is set when exactly one cache holds the block with permission to write it. Caches reach the controller with three kinds of request: a read miss, a write miss, and an upgrade that a cache sends when it writes a block it holds without write permission. A write to a block the cache already holds privately never reaches the controller.

For each accepted request the controller looks up the record and decides what must happen. It may answer at once. It may send invalidates to the other holders and wait for all their acknowledgements. It may forward a fetch to the single writer so that the writer hands its copy to the requester and to memory. When the transaction finishes, the controller rewrites the record, tells memory to take the writer's copy when that copy was dirty, and answers the requester. The answer names the request kind, so the requesting cache knows whether to set its private bit.

Requests arrive one at a time on a valid/ready channel. The controller handles one transaction at a time and refuses new requests until the current one is answered. Only control is modelled: data words and network routing are outside the block.

Top module: `full_map_dir_ctrl`

## Requirements
- R1: After reset every record is empty (no holder, sole-writer flag clear), `req_ready` is high, and `rsp_valid`, `wb_valid`, `inv_mask` and `upd_mask` are all zero.
- R2: A read miss (kind 0) on a block whose sole-writer flag is clear is answered in the cycle after acceptance with `rsp_kind` 0 and no invalidate or fetch. The requester's presence bit is set.
- R3: A read miss on a block whose sole-writer flag is set drives `upd_mask` one-hot on the writer in the cycle after acceptance. Once the writer acknowledges, the controller answers with `wb_valid` high. Afterwards both caches are holders and the flag is clear.
- R4: A write miss (kind 1) drives `inv_mask` with every holder except the requester, for one cycle, in the cycle after acceptance. It answers with `rsp_kind` 1.
- R5: A write miss or upgrade on a block whose sole writer is another cache raises `wb_valid` together with the answer. With the flag clear, `wb_valid` stays low.
- R6: When a write miss or upgrade completes, the requester is the only holder and the sole-writer flag is set. A later read miss by another cache therefore forwards a fetch to that requester.
- R7: An upgrade (kind 2) invalidates every other holder and answers with `rsp_kind` 2 once all of them have acknowledged.
- R8: A write miss or upgrade with no other holder is answered in the cycle after acceptance, with no invalidate sent.
- R9: `req_ready` is low from the cycle after a forwarding acceptance until the final acknowledgement is taken. A request presented meanwhile is accepted only afterwards.
- R10: The controller counts acknowledgements on `ack_in` (one bit per cache, and several may arrive in one cycle). It answers in the cycle after the count of received acknowledgements reaches the number sent.
- R11: Acknowledgements that arrive while no transaction is waiting have no effect and produce no answer.
- R12: Records of different blocks are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 upgrade |
| req_id | input | IDW | Requesting processor |
| req_blk | input | BW | Block index |
| inv_mask | output | N | One-cycle invalidate, one bit per cache |
| upd_mask | output | N | One-cycle fetch to the sole writer |
| ack_in | input | N | Acknowledgement pulses from caches |
| rsp_valid | output | 1 | One-cycle answer to the requester |
| rsp_kind | output | 2 | Kind of the request being answered |
| rsp_id | output | IDW | Processor being answered |
| rsp_blk | output | BW | Block being answered |
| wb_valid | output | 1 | Memory takes the writer's copy |

## Verification
A corrupted presence vector shows up at the next write miss or upgrade on that block, as a wrong `inv_mask` one cycle after acceptance. A sole-writer flag left set or cleared wrongly shows up at the next read miss, either as a fetch that should not happen or as a missing one, and the `wb_valid` pulse goes wrong with it. A miscounted acknowledgement total shows up as an answer that comes too early or never comes, with `req_ready` stuck low, within a few cycles of the last acknowledgement.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      KIND_RD_MISS = 2'd0,
      KIND_WR_MISS = 2'd1,
      KIND_UPGRADE = 2'd2,
      KIND_RSVD    = 2'd3
   } req_kind_e;
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
   parameter int N  = 4,
   parameter int NB = 16,
   localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [BW-1:0] rd_idx,
   output logic [N-1:0]  rd_pres,
   output logic          rd_sole,
   input  logic          wr_en,
   input  logic [BW-1:0] wr_idx,
   input  logic [N-1:0]  wr_pres,
   input  logic          wr_sole
);
   logic [N:0] ent_q [NB];

   for (genvar b = 0; b < NB; b++) begin : g_blk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q[b] <= '0;
         else if (wr_en && (wr_idx == BW'(b)))
            ent_q[b] <= {wr_sole, wr_pres};
      end
   end

   assign rd_pres = ent_q[rd_idx][N-1:0];
   assign rd_sole = ent_q[rd_idx][N];
endmodule

// File: rtl/dir_action_plan.sv
module dir_action_plan
   import dir_pkg::*;
#(
   parameter int N = 4,
   localparam int IDW = (N > 1) ? $clog2(N) : 1,
   localparam int CW  = $clog2(N + 1)
) (
   input  req_kind_e      kind,
   input  logic [IDW-1:0] id,
   input  logic [N-1:0]   pres,
   input  logic           sole,
   output logic [N-1:0]   inv_mask,
   output logic [N-1:0]   upd_mask,
   output logic [CW-1:0]  ack_need,
   output logic           wb_need,
   output logic [N-1:0]   nxt_pres,
   output logic           nxt_sole
);
   logic [N-1:0] req_oh;
   logic [N-1:0] others;

   always_comb begin
      req_oh     = '0;
      req_oh[id] = 1'b1;
      others     = pres & ~req_oh;
      inv_mask   = '0;
      upd_mask   = '0;
      wb_need    = 1'b0;
      if (kind == KIND_WR_MISS || kind == KIND_UPGRADE) begin
         inv_mask = others;
         wb_need  = sole && (others != '0);
         nxt_pres = req_oh;
         nxt_sole = 1'b1;
      end else begin
         if (sole) begin
            upd_mask = pres;
            wb_need  = 1'b1;
         end
         nxt_pres = pres | req_oh;
         nxt_sole = 1'b0;
      end
      ack_need = CW'($countones(inv_mask | upd_mask));
   end
endmodule

// File: rtl/dir_ack_tracker.sv
module dir_ack_tracker #(
   parameter int N = 4,
   localparam int CW = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic [CW-1:0] load_cnt,
   input  logic [N-1:0]  ack_in,
   output logic          busy,
   output logic          done
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] got;

   assign got  = CW'($countones(ack_in));
   assign busy = (cnt_q != '0);
   assign done = busy && (got >= cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_en)
         cnt_q <= load_cnt;
      else if (done)
         cnt_q <= '0;
      else if (busy)
         cnt_q <= cnt_q - got;
   end
endmodule

// File: rtl/full_map_dir_ctrl.sv
module full_map_dir_ctrl
   import dir_pkg::*;
#(
   parameter int N  = 4,
   parameter int NB = 16,
   localparam int IDW = (N > 1) ? $clog2(N) : 1,
   localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
   localparam int CW  = $clog2(N + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [1:0]     req_kind,
   input  logic [IDW-1:0] req_id,
   input  logic [BW-1:0]  req_blk,
   output logic [N-1:0]   inv_mask,
   output logic [N-1:0]   upd_mask,
   input  logic [N-1:0]   ack_in,
   output logic           rsp_valid,
   output logic [1:0]     rsp_kind,
   output logic [IDW-1:0] rsp_id,
   output logic [BW-1:0]  rsp_blk,
   output logic           wb_valid
);
   if (N < 2) begin : g_bad_n
      $error("full_map_dir_ctrl: N must be at least 2");
   end
   if (NB < 1) begin : g_bad_nb
      $error("full_map_dir_ctrl: NB must be at least 1");
   end

   logic [N-1:0]  cur_pres, pl_inv, pl_upd, pl_pres;
   logic          cur_sole, pl_wb, pl_sole;
   logic [CW-1:0] pl_need;
   logic          busy, done, accept, now_done;

   logic [1:0]     pend_kind;
   logic [IDW-1:0] pend_id;
   logic [BW-1:0]  pend_blk;
   logic [N-1:0]   pend_pres;
   logic           pend_sole, pend_wb;

   logic           st_we, st_sole;
   logic [BW-1:0]  st_idx;
   logic [N-1:0]   st_pres;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign now_done  = accept && (pl_need == '0);

   dir_entry_store #(.N(N), .NB(NB)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (req_blk),
      .rd_pres (cur_pres),
      .rd_sole (cur_sole),
      .wr_en   (st_we),
      .wr_idx  (st_idx),
      .wr_pres (st_pres),
      .wr_sole (st_sole)
   );

   dir_action_plan #(.N(N)) u_plan (
      .kind     (req_kind_e'(req_kind)),
      .id       (req_id),
      .pres     (cur_pres),
      .sole     (cur_sole),
      .inv_mask (pl_inv),
      .upd_mask (pl_upd),
      .ack_need (pl_need),
      .wb_need  (pl_wb),
      .nxt_pres (pl_pres),
      .nxt_sole (pl_sole)
   );

   dir_ack_tracker #(.N(N)) u_acks (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (accept),
      .load_cnt (pl_need),
      .ack_in   (ack_in),
      .busy     (busy),
      .done     (done)
   );

   always_comb begin
      st_we   = now_done || done;
      st_idx  = done ? pend_blk  : req_blk;
      st_pres = done ? pend_pres : pl_pres;
      st_sole = done ? pend_sole : pl_sole;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_kind <= '0;
         pend_id   <= '0;
         pend_blk  <= '0;
         pend_pres <= '0;
         pend_sole <= 1'b0;
         pend_wb   <= 1'b0;
      end else if (accept) begin
         pend_kind <= req_kind;
         pend_id   <= req_id;
         pend_blk  <= req_blk;
         pend_pres <= pl_pres;
         pend_sole <= pl_sole;
         pend_wb   <= pl_wb;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inv_mask  <= '0;
         upd_mask  <= '0;
         rsp_valid <= 1'b0;
         rsp_kind  <= '0;
         rsp_id    <= '0;
         rsp_blk   <= '0;
         wb_valid  <= 1'b0;
      end else begin
         inv_mask  <= accept ? pl_inv : '0;
         upd_mask  <= accept ? pl_upd : '0;
         rsp_valid <= now_done || done;
         wb_valid  <= done && pend_wb;
         if (now_done) begin
            rsp_kind <= req_kind;
            rsp_id   <= req_id;
            rsp_blk  <= req_blk;
         end else if (done) begin
            rsp_kind <= pend_kind;
            rsp_id   <= pend_id;
            rsp_blk  <= pend_blk;
         end
      end
   end
endmodule

// File: rtl/full_map_dir_chk.sv
module full_map_dir_chk #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_valid,
   input logic         req_ready,
   input logic [N-1:0] inv_mask,
   input logic [N-1:0] upd_mask,
   input logic         rsp_valid,
   input logic         wb_valid
);
   assert_upd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_mask));

   assert_fwd_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_mask != '0) |-> (inv_mask == '0));

   assert_busy_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((inv_mask != '0) || (upd_mask != '0)) |-> !req_ready);

   assert_rsp_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

   assert_accept_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_valid || (inv_mask != '0) || (upd_mask != '0)));

   assert_wb_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> rsp_valid);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> !rsp_valid);
endmodule

bind full_map_dir_ctrl full_map_dir_chk #(.N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .inv_mask  (inv_mask),
   .upd_mask  (upd_mask),
   .rsp_valid (rsp_valid),
   .wb_valid  (wb_valid)
);

// File: tb/sim_full_map_dir_ctrl.sv
module sim_full_map_dir_ctrl;
   localparam int N  = 4;
   localparam int NB = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [1:0] req_kind = '0;
   logic [1:0] req_id = '0;
   logic [3:0] req_blk = '0;
   logic [3:0] inv_mask, upd_mask;
   logic [3:0] ack_in = '0;
   logic       rsp_valid;
   logic [1:0] rsp_kind;
   logic [1:0] rsp_id;
   logic [3:0] rsp_blk;
   logic       wb_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   full_map_dir_ctrl #(.N(N), .NB(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_id(req_id), .req_blk(req_blk),
      .inv_mask(inv_mask), .upd_mask(upd_mask), .ack_in(ack_in),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_id(rsp_id),
      .rsp_blk(rsp_blk), .wb_valid(wb_valid)
   );

   typedef struct packed {
      logic [3:0] tag;
      logic [1:0] kind;
      logic [1:0] id;
      logic [3:0] blk;
      logic [3:0] inv;
      logic [3:0] upd;
      logic       wb;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{4'd2,  2'd0, 2'd0, 4'd3, 4'b0000, 4'b0000, 1'b0}, // R2 first reader
      '{4'd2,  2'd0, 2'd1, 4'd3, 4'b0000, 4'b0000, 1'b0}, // R2 second reader
      '{4'd2,  2'd0, 2'd2, 4'd3, 4'b0000, 4'b0000, 1'b0}, // R2 third reader
      '{4'd4,  2'd1, 2'd3, 4'd3, 4'b0111, 4'b0000, 1'b0}, // R4 write miss, three sharers
      '{4'd3,  2'd0, 2'd0, 4'd3, 4'b0000, 4'b1000, 1'b1}, // R3 fetch from writer 3
      '{4'd3,  2'd0, 2'd2, 4'd3, 4'b0000, 4'b0000, 1'b0}, // R3 flag now clear
      '{4'd7,  2'd2, 2'd2, 4'd3, 4'b1001, 4'b0000, 1'b0}, // R7 upgrade, flag clear
      '{4'd5,  2'd1, 2'd1, 4'd3, 4'b0100, 4'b0000, 1'b1}, // R5 write miss over writer 2
      '{4'd8,  2'd1, 2'd0, 4'd5, 4'b0000, 4'b0000, 1'b0}, // R8 R12 uncached block
      '{4'd6,  2'd0, 2'd3, 4'd5, 4'b0000, 4'b0001, 1'b1}, // R6 writer 0 owns block 5
      '{4'd8,  2'd2, 2'd1, 4'd3, 4'b0000, 4'b0000, 1'b0}, // R8 upgrade by sole holder
      '{4'd6,  2'd0, 2'd0, 4'd3, 4'b0000, 4'b0010, 1'b1}  // R6 upgrade made 1 writer
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // drive a request at a falling edge; return at the falling edge after acceptance
   task automatic issue(input logic [1:0] k, input logic [1:0] i, input logic [3:0] b);
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = k;
      req_id    = i;
      req_blk   = b;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(req_ready === 1'b1, "R1", "ready in reset", int'(req_ready), 1);
      check(rsp_valid === 1'b0 && wb_valid === 1'b0, "R1", "rsp/wb in reset",
            int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(inv_mask === 4'b0 && upd_mask === 4'b0, "R1", "masks after reset",
            int'(inv_mask | upd_mask), 0);

      for (int v = 0; v < NV; v++) begin
         vec_t t;
         string tg;
         t  = VEC[v];
         tg = $sformatf("R%0d", t.tag);
         issue(t.kind, t.id, t.blk);
         check(inv_mask === t.inv, tg, $sformatf("vec %0d inv_mask", v),
               int'(inv_mask), int'(t.inv));
         check(upd_mask === t.upd, tg, $sformatf("vec %0d upd_mask", v),
               int'(upd_mask), int'(t.upd));
         if ((t.inv | t.upd) != 4'b0) begin
            check(rsp_valid === 1'b0, tg, $sformatf("vec %0d early rsp", v),
                  int'(rsp_valid), 0);
            ack_in = t.inv | t.upd;
            @(negedge clk);
            ack_in = '0;
         end
         check(rsp_valid === 1'b1, tg, $sformatf("vec %0d rsp_valid", v),
               int'(rsp_valid), 1);
         check(rsp_kind === t.kind && rsp_id === t.id && rsp_blk === t.blk, tg,
               $sformatf("vec %0d rsp kind/id/blk", v),
               int'({rsp_kind, rsp_id, rsp_blk}), int'({t.kind, t.id, t.blk}));
         check(wb_valid === t.wb, tg, $sformatf("vec %0d wb_valid", v),
               int'(wb_valid), int'(t.wb));
      end

      // R9 R10: acknowledgements one per cycle, request held while busy
      issue(2'd0, 2'd0, 4'd7);
      issue(2'd0, 2'd1, 4'd7);
      issue(2'd0, 2'd2, 4'd7);
      issue(2'd1, 2'd3, 4'd7);
      check(inv_mask === 4'b0111, "R4", "blk7 inv_mask", int'(inv_mask), 7);
      req_valid = 1'b1; req_kind = 2'd0; req_id = 2'd0; req_blk = 4'd9;
      ack_in = 4'b0001;
      @(negedge clk);
      check(rsp_valid === 1'b0, "R10", "rsp after 1 of 3 acks", int'(rsp_valid), 0);
      check(req_ready === 1'b0, "R9", "ready while waiting", int'(req_ready), 0);
      ack_in = 4'b0010;
      @(negedge clk);
      check(rsp_valid === 1'b0, "R10", "rsp after 2 of 3 acks", int'(rsp_valid), 0);
      check(req_ready === 1'b0, "R9", "held request not taken", int'(req_ready), 0);
      ack_in = 4'b0100;
      @(negedge clk);
      ack_in = '0;
      check(rsp_valid === 1'b1 && rsp_id === 2'd3 && rsp_kind === 2'd1, "R10",
            "rsp after last ack", int'({rsp_valid, rsp_kind, rsp_id}), 'b1_01_11);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid === 1'b1 && rsp_id === 2'd0 && rsp_blk === 4'd9, "R9",
            "held request answered", int'({rsp_valid, rsp_id, rsp_blk}), 'b1_00_1001);

      // R11: stray acknowledgements while idle
      @(negedge clk);
      ack_in = 4'b1111;
      @(negedge clk);
      ack_in = '0;
      check(rsp_valid === 1'b0, "R11", "no rsp on idle acks", int'(rsp_valid), 0);
      check(req_ready === 1'b1, "R11", "ready after idle acks", int'(req_ready), 1);
      issue(2'd1, 2'd0, 4'd7);
      check(inv_mask === 4'b1000, "R11", "blk7 inv after idle acks", int'(inv_mask), 8);
      check(rsp_valid === 1'b0, "R11", "no early rsp", int'(rsp_valid), 0);
      ack_in = 4'b1000;
      @(negedge clk);
      ack_in = '0;
      check(rsp_valid === 1'b1 && wb_valid === 1'b1, "R5", "blk7 wb with rsp",
            int'({rsp_valid, wb_valid}), 3);

      finish_run();
   end
endmodule